// File: doc/BRIEF.md
# Edge- or Center-Aligned PWM Channel with Double-Buffered Compare

This block is one pulse-width modulation channel. A timer advances once for each count pulse it is given. Each timer cycle is compared against two limits: a period limit and a pulse-width limit. A mode input chooses how the timer moves. In edge-aligned mode it ramps upward and wraps to zero. In center-aligned mode it climbs to the period limit and then descends back to zero.

Software writes the two limits into working registers. The comparator reads them only through a second, shadow copy of each. The shadow copies are refreshed at the boundary between timer cycles, so a new setting never takes effect partway through a cycle.

At each boundary the channel also raises a single-clock interrupt request. A run input stops the channel and parks the timer at zero.

Top module: `pwm_chan_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `pwm_out` and `cyc_irq` are low. The timer is zero and counting upward. The shadow period and shadow width hold the parameter values `PER_INIT` and `PW_INIT`.
- R2: With `mode_sel`=0 (edge-aligned), each count pulse raises the timer by one. The pulse taken while the timer equals the shadow period P returns it to zero. `pwm_out` is high exactly when the timer is at or above the shadow width W. With P=7 and W set to 1, 2, 4, 6 or 7, the output is high for 7, 6, 4, 2 or 1 of every 8 pulses.
- R3: A shadow width of zero keeps `pwm_out` high on every running cycle after the first count pulse, in either mode.
- R4: A shadow width larger than the shadow period keeps `pwm_out` low in either mode.
- R5: In edge-aligned mode, the pulse that returns the timer to zero also copies both working registers into the shadows. It also makes `cyc_irq` high for the clock that follows that edge.
- R6: With `mode_sel`=1 (center-aligned), the timer climbs to P. The next pulse keeps the value P and turns the direction down. Later pulses step down to zero. The pulse taken at zero while going down keeps zero, turns the direction up, loads the shadows and raises `cyc_irq`. One output period is therefore 2(P+1) pulses.
- R7: In center-aligned mode, `pwm_out` rises on the upward slope where the timer reaches W. It falls on the downward slope where the timer drops below W. It changes on the same edge as the timer.
- R8: With `run_en` high and `cnt_en` low, the timer, direction and `pwm_out` keep their values and `cyc_irq` is low.
- R9: With `run_en` low, the timer is forced to zero and counting upward. `pwm_out` and `cyc_irq` are low whatever `cnt_en` does.
- R10: `per_we`/`pw_we` update only the working registers. The shadows change only at a cycle end, and they take the working values held before that edge.
- R11: Every cycle end produces exactly one clock of `cyc_irq`. If P>0, the clock after any `cyc_irq` pulse has it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Channel run enable; low parks the timer |
| cnt_en | input | 1 | Count pulse, one clock wide per timer step |
| mode_sel | input | 1 | 0 = edge-aligned, 1 = center-aligned |
| per_we | input | 1 | Write strobe for the working period register |
| per_wdata | input | W | Period value to write |
| pw_we | input | 1 | Write strobe for the working width register |
| pw_wdata | input | W | Width value to write |
| pwm_out | output | 1 | Modulated output |
| cyc_irq | output | 1 | One-clock request at each cycle end |

## Verification
The assertions assume that `mode_sel` changes only while `run_en` is low. A switch in mid-cycle would leave the direction flag in a state that neither mode defines. The bench changes mode only during stopped phases, and each stop returns the direction to up.

The irq-spacing property also assumes the shadow period is non-zero. The bench therefore drives a zero period only in center-aligned mode, where cycle ends are still spaced apart. Register writes arrive at arbitrary points in a timer cycle, which exercises the shadow boundary.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  parameter int unsigned PWM_CNT_W_DEF = 16;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } cnt_dir_e;

  typedef enum logic {
    MODE_EDGE   = 1'b0,
    MODE_CENTER = 1'b1
  } pwm_mode_e;

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_chan_pkg::*;
#(
  parameter int unsigned      W        = PWM_CNT_W_DEF,
  parameter logic [W-1:0]     PER_INIT = 7,
  parameter logic [W-1:0]     PW_INIT  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         per_we,
  input  logic [W-1:0] per_wdata,
  input  logic         pw_we,
  input  logic [W-1:0] pw_wdata,
  input  logic         load,
  output logic [W-1:0] per_sh,
  output logic [W-1:0] pw_sh,
  output logic [W-1:0] pw_eff
);

  logic [W-1:0] per_wk_q, per_wk_d;
  logic [W-1:0] pw_wk_q,  pw_wk_d;
  logic [W-1:0] per_sh_q, per_sh_d;
  logic [W-1:0] pw_sh_q,  pw_sh_d;

  // working registers: software side only
  always_comb begin
    per_wk_d = per_wk_q;
    pw_wk_d  = pw_wk_q;
    if (per_we) per_wk_d = per_wdata;
    if (pw_we)  pw_wk_d  = pw_wdata;
  end

  // shadow copies: refreshed only at a cycle boundary
  always_comb begin
    per_sh_d = per_sh_q;
    pw_sh_d  = pw_sh_q;
    if (load) begin
      per_sh_d = per_wk_q;
      pw_sh_d  = pw_wk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_wk_q <= PER_INIT;
      pw_wk_q  <= PW_INIT;
      per_sh_q <= PER_INIT;
      pw_sh_q  <= PW_INIT;
    end else begin
      per_wk_q <= per_wk_d;
      pw_wk_q  <= pw_wk_d;
      per_sh_q <= per_sh_d;
      pw_sh_q  <= pw_sh_d;
    end
  end

  assign per_sh = per_sh_q;
  assign pw_sh  = pw_sh_q;
  // width in force after the current edge
  assign pw_eff = pw_sh_d;

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_chan_pkg::*;
#(
  parameter int unsigned W = PWM_CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         cnt_en,
  input  pwm_mode_e    mode,
  input  logic [W-1:0] per_sh,
  output logic [W-1:0] timer_q,
  output logic [W-1:0] timer_d,
  output cnt_dir_e     dir_q,
  output logic         cyc_end
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  cnt_dir_e dir_d;
  logic     at_top;
  logic     at_bot;

  assign at_top = (timer_q >= per_sh);
  assign at_bot = (timer_q == ZERO);

  always_comb begin
    timer_d = timer_q;
    dir_d   = dir_q;
    cyc_end = 1'b0;
    if (!run_en) begin
      timer_d = ZERO;
      dir_d   = DIR_UP;
    end else if (cnt_en) begin
      if (mode == MODE_EDGE) begin
        dir_d = DIR_UP;
        if (at_top) begin
          timer_d = ZERO;
          cyc_end = 1'b1;
        end else begin
          timer_d = timer_q + ONE;
        end
      end else if (dir_q == DIR_UP) begin
        if (at_top) dir_d = DIR_DN;       // turnaround pulse holds value
        else        timer_d = timer_q + ONE;
      end else begin
        if (at_bot) begin
          dir_d   = DIR_UP;
          cyc_end = 1'b1;
        end else begin
          timer_d = timer_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= ZERO;
      dir_q   <= DIR_UP;
    end else begin
      timer_q <= timer_d;
      dir_q   <= dir_d;
    end
  end

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_chan_pkg::*;
#(
  parameter int unsigned W = PWM_CNT_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         cnt_en,
  input  logic         cyc_end,
  input  logic [W-1:0] timer_d,
  input  logic [W-1:0] pw_eff,
  output logic         out_q,
  output logic         irq_q
);

  logic out_d;
  logic irq_d;

  // the comparison is taken against the timer value and width that will
  // both be in force after this edge, so output and timer move together
  always_comb begin
    out_d = out_q;
    if (!run_en)     out_d = 1'b0;
    else if (cnt_en) out_d = (timer_d >= pw_eff);
    irq_d = cyc_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      out_q <= out_d;
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int unsigned  W        = PWM_CNT_W_DEF,
  parameter logic [W-1:0] PER_INIT = 7,
  parameter logic [W-1:0] PW_INIT  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         cnt_en,
  input  logic         mode_sel,
  input  logic         per_we,
  input  logic [W-1:0] per_wdata,
  input  logic         pw_we,
  input  logic [W-1:0] pw_wdata,
  output logic         pwm_out,
  output logic         cyc_irq
);

  pwm_mode_e    mode;
  logic [W-1:0] per_sh;
  logic [W-1:0] pw_sh;
  logic [W-1:0] pw_eff;
  logic [W-1:0] timer_q;
  logic [W-1:0] timer_d;
  cnt_dir_e     dir_q;
  logic         cyc_end;

  assign mode = pwm_mode_e'(mode_sel);

  pwm_shadow_regs #(
    .W(W), .PER_INIT(PER_INIT), .PW_INIT(PW_INIT)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_we    (per_we),
    .per_wdata (per_wdata),
    .pw_we     (pw_we),
    .pw_wdata  (pw_wdata),
    .load      (cyc_end),
    .per_sh    (per_sh),
    .pw_sh     (pw_sh),
    .pw_eff    (pw_eff)
  );

  pwm_timer #(.W(W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .cnt_en  (cnt_en),
    .mode    (mode),
    .per_sh  (per_sh),
    .timer_q (timer_q),
    .timer_d (timer_d),
    .dir_q   (dir_q),
    .cyc_end (cyc_end)
  );

  pwm_compare #(.W(W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .cnt_en  (cnt_en),
    .cyc_end (cyc_end),
    .timer_d (timer_d),
    .pw_eff  (pw_eff),
    .out_q   (pwm_out),
    .irq_q   (cyc_irq)
  );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         cnt_en,
  input logic         pwm_out,
  input logic         cyc_irq,
  input logic [W-1:0] timer_q,
  input logic         dir_q,
  input logic [W-1:0] per_sh,
  input logic [W-1:0] pw_sh
);

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    timer_q <= per_sh); // R2

  AST_END_PARKS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_irq |-> (timer_q == '0 && dir_q == 1'b0)); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_irq && per_sh != '0) |=> !cyc_irq); // R11

  AST_STOP_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (timer_q == '0 && dir_q == 1'b0 && !pwm_out && !cyc_irq)); // R9

  AST_NO_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cnt_en) |=> ($stable(timer_q) && $stable(dir_q) && $stable(pwm_out) && !cyc_irq)); // R8

  AST_SHADOW_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_irq |-> ($stable(per_sh) && $stable(pw_sh))); // R10

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en && cnt_en) && run_en && pw_sh == '0) |-> pwm_out); // R3

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_sh > per_sh) |-> !pwm_out); // R4

endmodule

bind pwm_chan_ctrl pwm_chan_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run_en  (run_en),
  .cnt_en  (cnt_en),
  .pwm_out (pwm_out),
  .cyc_irq (cyc_irq),
  .timer_q (timer_q),
  .dir_q   (dir_q),
  .per_sh  (per_sh),
  .pw_sh   (pw_sh)
);

// File: tb/tb_pwm_chan_ctrl.sv
`timescale 1ns/1ps
module tb_pwm_chan_ctrl;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         run_en, cnt_en, mode_sel;
  logic         per_we, pw_we;
  logic [W-1:0] per_wdata, pw_wdata;
  logic         pwm_out, cyc_irq;

  always #2.5 clk = ~clk;

  pwm_chan_ctrl #(.W(W), .PER_INIT(16'd7), .PW_INIT(16'd4)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_en(cnt_en),
    .mode_sel(mode_sel), .per_we(per_we), .per_wdata(per_wdata),
    .pw_we(pw_we), .pw_wdata(pw_wdata), .pwm_out(pwm_out), .cyc_irq(cyc_irq)
  );

  typedef struct {
    logic  out;
    logic  irq;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state, built from the requirements
  logic [W-1:0] m_t, m_per_w, m_pw_w, m_per_s, m_pw_s;
  logic         m_dn, m_out;

  // pending register writes, consumed by the next step
  logic         p_per_we, p_pw_we;
  logic [W-1:0] p_per, p_pw;

  task automatic expect_now(input logic o, input logic i, input string tag);
    checks++;
    if (pwm_out !== o || cyc_irq !== i) begin
      fails++;
      $display("FAIL %s: out=%0b irq=%0b expected out=%0b irq=%0b", tag, pwm_out, cyc_irq, o, i);
    end
  endtask

  task automatic step(input logic c, input logic r, input logic md, input string tag);
    logic [W-1:0] nt;
    logic         nd, e;
    exp_t         it;
    @(negedge clk);
    cnt_en = c; run_en = r; mode_sel = md;
    per_we = p_per_we; per_wdata = p_per;
    pw_we  = p_pw_we;  pw_wdata  = p_pw;
    nt = m_t; nd = m_dn; e = 1'b0;
    if (!r) begin
      nt = '0; nd = 1'b0;
    end else if (c) begin
      if (!md) begin
        nd = 1'b0;
        if (m_t >= m_per_s) begin nt = '0; e = 1'b1; end
        else nt = m_t + 1'b1;
      end else if (!m_dn) begin
        if (m_t >= m_per_s) nd = 1'b1;
        else nt = m_t + 1'b1;
      end else begin
        if (m_t == '0) begin nd = 1'b0; e = 1'b1; end
        else nt = m_t - 1'b1;
      end
    end
    if (e) begin m_per_s = m_per_w; m_pw_s = m_pw_w; end
    if (!r)     m_out = 1'b0;
    else if (c) m_out = (nt >= m_pw_s);
    m_t = nt; m_dn = nd;
    if (p_per_we) m_per_w = p_per;
    if (p_pw_we)  m_pw_w  = p_pw;
    p_per_we = 1'b0; p_pw_we = 1'b0;
    it.out = m_out; it.irq = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic run_n(input int n, input int gap, input logic md, input string tag);
    for (int i = 0; i < n; i++) step((gap == 0) || (i % gap == 0), 1'b1, md, tag);
  endtask

  task automatic set_regs(input logic [W-1:0] per, input logic [W-1:0] pw);
    p_per_we = 1'b1; p_per = per;
    p_pw_we  = 1'b1; p_pw  = pw;
  endtask

  // monitor: pops one expected item per clock, just after the edge
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        expect_now(it.out, it.irq, it.tag);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: out=%0b irq=%0b expected run to finish", pwm_out, cyc_irq);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; cnt_en = 1'b0; mode_sel = 1'b0;
    per_we = 1'b0; pw_we = 1'b0; per_wdata = '0; pw_wdata = '0;
    p_per_we = 1'b0; p_pw_we = 1'b0; p_per = '0; p_pw = '0;
    m_t = '0; m_dn = 1'b0; m_out = 1'b0;
    m_per_w = 16'd7; m_pw_w = 16'd4; m_per_s = 16'd7; m_pw_s = 16'd4;
    repeat (3) @(negedge clk);
    #1 expect_now(1'b0, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    expect_now(1'b0, 1'b0, "R1");

    // R1: first cycles run on reset shadow values (P=7, W=4)
    run_n(16, 0, 1'b0, "R1");
    // R10: write mid-cycle, old shadows stay until the wrap
    run_n(3, 0, 1'b0, "R10");
    set_regs(16'd5, 16'd2);
    run_n(14, 0, 1'b0, "R10");
    // R2/R3/R4/R5: duty sweep at P=7
    begin
      logic [W-1:0] pws [7] = '{16'd0, 16'd1, 16'd2, 16'd4, 16'd6, 16'd7, 16'd8};
      foreach (pws[k]) begin
        set_regs(16'd7, pws[k]);
        if (pws[k] == 0)      run_n(20, 0, 1'b0, "R3");
        else if (pws[k] > 7)  run_n(20, 0, 1'b0, "R4");
        else                  run_n(20, 0, 1'b0, "R2_R5");
      end
    end
    // R8: sparse count pulses
    set_regs(16'd4, 16'd2);
    run_n(40, 3, 1'b0, "R8");
    // R9: stop with pulses present, switch to center mode while stopped
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, "R9");
    // R6/R7: center-aligned, then width changes
    set_regs(16'd5, 16'd2);
    run_n(40, 0, 1'b1, "R6_R7");
    set_regs(16'd5, 16'd0);
    run_n(30, 0, 1'b1, "R3");
    set_regs(16'd5, 16'd6);
    run_n(30, 0, 1'b1, "R4");
    set_regs(16'd0, 16'd0);
    run_n(16, 0, 1'b1, "R11");
    set_regs(16'd3, 16'd2);
    run_n(30, 2, 1'b1, "R8");
    run_n(20, 0, 1'b1, "R11");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, "R9");
    run_n(20, 0, 1'b0, "R5");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule